// File: doc/BRIEF.md
# Ping-Pong Audio Sample Memory Packer

This block sits behind an audio receiver. Each accepted sample pair (a left and a right sample) is reduced to bytes in one of four memory layouts: 8-bit mono, 8-bit stereo, 16-bit mono or 16-bit stereo. Little-endian or big-endian byte order can be selected. The bytes are gathered into 32-bit words. Each complete word is issued as a write request that stays up until the memory side acknowledges it.

Words go into two software-owned buffers in turn. Each buffer has a base address and a byte length. Software arms a buffer to hand it to the block. When the last word of a buffer is acknowledged, the block flags that buffer full and moves to the other one. If the other buffer has not been armed, the block drops incoming samples and raises a sticky overrun flag until software arms a buffer again.

Top module: `audio_dma_packer`

## Requirements
- R1: `cfg_fmt` selects the layout: 0 = 8-bit mono (1 byte per pair), 1 = 8-bit stereo (2 bytes), 2 = 16-bit mono (2 bytes), 3 = 16-bit stereo (4 bytes). An 8-bit byte is the upper 8 bits of the sample with its top bit inverted. A 16-bit value is stored unchanged.
- R2: In stereo layouts the left sample's bytes occupy lower addresses than the right sample's bytes. Mono layouts use only the left sample.
- R3: With `cfg_big_endian`=0, the byte at word offset i lies in `req_data[8i+7:8i]`, and a 16-bit sample puts its low byte at the lower address. With `cfg_big_endian`=1, the byte at offset i lies in `req_data[31-8i:24-8i]`, and the high byte goes at the lower address.
- R4: `req_valid` rises on the clock after the sample that completes a word is accepted, never for a partial word. While `req_ack` is low, `req_valid`, `req_addr` and `req_data` hold steady.
- R5: `req_addr` equals the active buffer's base plus a byte offset. The offset starts at 0 and grows by 4 with each acknowledged word.
- R6: Acknowledging the word at offset length-4 sets that buffer's `buf_full` bit. It also un-arms the buffer, flips `cur_buf` and restarts the offset at 0 in the other buffer.
- R7: A one-cycle pulse on `buf_arm[i]` arms buffer i, clears `buf_full[i]` and clears `overrun`.
- R8: A sample presented while the active buffer is unarmed is dropped and sets `overrun`. So is a sample that would complete a word while a request is still pending. A dropped sample leaves no bytes in any later word.
- R9: While `rst_n` is low, and just after it is released, `req_valid`, `buf_full` and `overrun` are 0, `cur_buf` is 0 and no buffer is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Memory layout select (R1) |
| cfg_big_endian | input | 1 | Byte order select |
| smp_valid | input | 1 | A sample pair is presented this cycle |
| smp_left | input | SMP_W | Left sample, two's complement |
| smp_right | input | SMP_W | Right sample, two's complement |
| buf0_base | input | ADDR_W | Byte base address of buffer 0 |
| buf0_len | input | LEN_W | Length of buffer 0 in bytes, multiple of 4 |
| buf1_base | input | ADDR_W | Byte base address of buffer 1 |
| buf1_len | input | LEN_W | Length of buffer 1 in bytes, multiple of 4 |
| buf_arm | input | 2 | Per-buffer arm pulse |
| req_valid | output | 1 | Write request pending |
| req_addr | output | ADDR_W | Write byte address |
| req_data | output | 32 | Write data word |
| req_ack | input | 1 | Memory side accepts the pending write |
| buf_full | output | 2 | Per-buffer full flag |
| overrun | output | 1 | Sticky sample-drop flag |
| cur_buf | output | 1 | Index of the buffer being filled |

## Verification
The bench builds the block with the default parameters: 32-bit addresses, 16-bit lengths and 16-bit samples. It programs buffers of only 8 and 12 bytes, so a run of a few words reaches a buffer switch, both buffers full at once, re-arming and the overrun path. With 16-bit samples, all four layouts and both byte orders can be checked bit-exactly, including the inversion of the top bit for 8-bit output. A stalled acknowledge makes a completing sample collide with a pending request.

// File: rtl/adp_pkg.sv
// Shared definitions for the audio sample memory packer.
package adp_pkg;
    // Memory layout codes as seen on cfg_fmt
    typedef enum logic [1:0] {
        FMT_MONO8    = 2'd0,
        FMT_STEREO8  = 2'd1,
        FMT_MONO16   = 2'd2,
        FMT_STEREO16 = 2'd3
    } adp_fmt_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned BYTE_CNT_W = 3;
endpackage

// File: rtl/adp_byte_former.sv
// Turns one sample pair into its bytes in memory-address order.
// Assumes SMP_W >= 16; only the upper 16 bits of each sample are used.
// Purely combinational; out_cnt is 1, 2 or 4.
module adp_byte_former
    import adp_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  adp_fmt_e                    fmt,
    input  logic                        big_endian,
    input  logic [SMP_W-1:0]            left,
    input  logic [SMP_W-1:0]            right,
    output logic [WORD_BYTES-1:0][7:0]  out_bytes,
    output logic [BYTE_CNT_W-1:0]       out_cnt
);
    logic [7:0] l_hi, l_lo, r_hi, r_lo;
    logic [7:0] l_u8, r_u8;

    assign l_hi = left[SMP_W-1 -: 8];
    assign l_lo = left[SMP_W-9 -: 8];
    assign r_hi = right[SMP_W-1 -: 8];
    assign r_lo = right[SMP_W-9 -: 8];
    // Offset-binary 8-bit forms: invert the sign bit
    assign l_u8 = {~l_hi[7], l_hi[6:0]};
    assign r_u8 = {~r_hi[7], r_hi[6:0]};

    // Select the byte sequence for the chosen layout and byte order
    always_comb begin
        out_bytes = '0;
        out_cnt   = '0;
        unique case (fmt)
            FMT_MONO8: begin
                out_bytes[0] = l_u8;
                out_cnt      = 3'd1;
            end
            FMT_STEREO8: begin
                out_bytes[0] = l_u8;
                out_bytes[1] = r_u8;
                out_cnt      = 3'd2;
            end
            FMT_MONO16: begin
                out_bytes[0] = big_endian ? l_hi : l_lo;
                out_bytes[1] = big_endian ? l_lo : l_hi;
                out_cnt      = 3'd2;
            end
            default: begin
                out_bytes[0] = big_endian ? l_hi : l_lo;
                out_bytes[1] = big_endian ? l_lo : l_hi;
                out_bytes[2] = big_endian ? r_hi : r_lo;
                out_bytes[3] = big_endian ? r_lo : r_hi;
                out_cnt      = 3'd4;
            end
        endcase
    end
endmodule

// File: rtl/adp_word_assembler.sv
// Collects bytes into a 32-bit word and places each byte in the lane its
// address offset and the byte order call for.
// Assumes the layout does not change part-way through a word.
// word_out already includes the bytes offered this cycle.
module adp_word_assembler
    import adp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  logic                        big_endian,
    input  logic [WORD_BYTES-1:0][7:0]  in_bytes,
    input  logic [BYTE_CNT_W-1:0]       in_cnt,
    output logic                        completes,
    output logic [8*WORD_BYTES-1:0]     word_out
);
    logic [WORD_BYTES-1:0][7:0] stage_q;
    logic [WORD_BYTES-1:0][7:0] merged;
    logic [1:0]                 pos_q;
    logic [3:0]                 fill_end;

    assign fill_end  = {2'b00, pos_q} + {1'b0, in_cnt};
    assign completes = (fill_end == 4'(WORD_BYTES));

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        logic [1:0] rel;
        logic       hit;
        // Offset of this lane within the incoming byte group
        assign rel = 2'(k) - pos_q;
        assign hit = ({2'b00, pos_q} <= 4'(k)) && (4'(k) < fill_end);
        assign merged[k] = hit ? in_bytes[rel] : stage_q[k];
        // Place address-order byte into its data lane
        assign word_out[8*k +: 8] = big_endian ? merged[WORD_BYTES-1-k] : merged[k];
    end

    // Hold staged bytes and the next free byte position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            pos_q   <= '0;
        end else if (take) begin
            stage_q <= merged;
            pos_q   <= pos_q + in_cnt[1:0];
        end
    end
endmodule

// File: rtl/adp_buffer_ctrl.sv
// Ping-pong buffer sequencing: tracks the armed and full state of two
// buffers, the active one, and the byte offset inside it.
// Assumes lengths are non-zero multiples of 4 and bases are word aligned.
module adp_buffer_ctrl #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base0,
    input  logic [LEN_W-1:0]  len0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [LEN_W-1:0]  len1,
    input  logic [1:0]        arm,
    input  logic              word_done,
    output logic              cur_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        full,
    output logic              active
);
    localparam int LW1 = LEN_W + 1;

    logic [1:0]        ready_q, full_q;
    logic              act_q;
    logic [LEN_W-1:0]  offset_q;
    logic [LEN_W-1:0]  len_cur;
    logic [ADDR_W-1:0] base_cur;
    logic              last_word;

    assign len_cur   = act_q ? len1 : len0;
    assign base_cur  = act_q ? base1 : base0;
    assign last_word = ({1'b0, offset_q} + LW1'(4)) == {1'b0, len_cur};
    assign cur_ready = ready_q[act_q];
    assign wr_addr   = base_cur + ADDR_W'(offset_q);
    assign full      = full_q;
    assign active    = act_q;

    // Advance the offset, retire a filled buffer, apply arm pulses last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= '0;
            full_q   <= '0;
            act_q    <= 1'b0;
            offset_q <= '0;
        end else begin
            if (word_done) begin
                if (last_word) begin
                    full_q[act_q]  <= 1'b1;
                    ready_q[act_q] <= 1'b0;
                    act_q          <= ~act_q;
                    offset_q       <= '0;
                end else begin
                    offset_q <= offset_q + LEN_W'(4);
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (arm[i]) begin
                    ready_q[i] <= 1'b1;
                    full_q[i]  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/audio_dma_packer.sv
// Top: packs audio sample pairs into 32-bit words and issues them as
// held write requests into two alternating software-armed buffers.
// Assumes cfg_fmt and cfg_big_endian change only on word boundaries.
// A sample that cannot be taken is dropped and raises a sticky overrun.
module audio_dma_packer
    import adp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_big_endian,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_left,
    input  logic [SMP_W-1:0]  smp_right,
    input  logic [ADDR_W-1:0] buf0_base,
    input  logic [LEN_W-1:0]  buf0_len,
    input  logic [ADDR_W-1:0] buf1_base,
    input  logic [LEN_W-1:0]  buf1_len,
    input  logic [1:0]        buf_arm,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [31:0]       req_data,
    input  logic              req_ack,
    output logic [1:0]        buf_full,
    output logic              overrun,
    output logic              cur_buf
);
    localparam int DATA_W = 8 * WORD_BYTES;

    adp_fmt_e                   fmt;
    logic [WORD_BYTES-1:0][7:0] pair_bytes;
    logic [BYTE_CNT_W-1:0]      pair_cnt;
    logic                       completes;
    logic [DATA_W-1:0]          word;
    logic                       cur_ready;
    logic                       accept, drop, word_done;
    logic                       req_valid_q, overrun_q;
    logic [DATA_W-1:0]          req_data_q;

    assign fmt = adp_fmt_e'(cfg_fmt);

    adp_byte_former #(.SMP_W(SMP_W)) u_former (
        .fmt        (fmt),
        .big_endian (cfg_big_endian),
        .left       (smp_left),
        .right      (smp_right),
        .out_bytes  (pair_bytes),
        .out_cnt    (pair_cnt)
    );

    adp_word_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (accept),
        .big_endian (cfg_big_endian),
        .in_bytes   (pair_bytes),
        .in_cnt     (pair_cnt),
        .completes  (completes),
        .word_out   (word)
    );

    adp_buffer_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base0      (buf0_base),
        .len0       (buf0_len),
        .base1      (buf1_base),
        .len1       (buf1_len),
        .arm        (buf_arm),
        .word_done  (word_done),
        .cur_ready  (cur_ready),
        .wr_addr    (req_addr),
        .full       (buf_full),
        .active     (cur_buf)
    );

    assign accept    = smp_valid && cur_ready && !(completes && req_valid_q);
    assign drop      = smp_valid && !accept;
    assign word_done = req_valid_q && req_ack;

    // Load a finished word into the request register; release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_q <= 1'b0;
            req_data_q  <= '0;
        end else if (accept && completes) begin
            req_valid_q <= 1'b1;
            req_data_q  <= word;
        end else if (word_done) begin
            req_valid_q <= 1'b0;
        end
    end

    // Sticky overrun: a drop sets it, any arm pulse clears it
    always_ff @(posedge clk) begin
        if (!rst_n)          overrun_q <= 1'b0;
        else if (drop)       overrun_q <= 1'b1;
        else if (|buf_arm)   overrun_q <= 1'b0;
    end

    assign req_valid = req_valid_q;
    assign req_data  = req_data_q;
    assign overrun   = overrun_q;
endmodule

// File: rtl/adp_checker.sv
// Property checker for audio_dma_packer, attached through bind.
// Observes top-level ports only.
module adp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [1:0]        buf_arm,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_data,
    input logic              req_ack,
    input logic [1:0]        buf_full,
    input logic              overrun,
    input logic              cur_buf
);
    // R4: an unacknowledged request is held unchanged
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

    // R6: a full flag rises only from an acknowledged write
    assert_full0_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full[0]) |-> $past(req_valid && req_ack));
    assert_full1_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full[1]) |-> $past(req_valid && req_ack));

    // R6: the active buffer changes only on an acknowledged write
    assert_switch_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_buf) |-> $past(req_valid && req_ack));

    // R7: arming clears the full flag of that buffer
    assert_arm_clears_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_arm[0] |=> !buf_full[0]);

    // R7: arming without a colliding sample clears overrun
    assert_arm_clears_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|buf_arm) && !smp_valid) |=> !overrun);

    // R8: overrun only rises after a presented sample
    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(smp_valid));

    // R9: clean state right after reset release
    assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!req_valid && buf_full == 2'b00 && !overrun && !cur_buf));
endmodule

bind audio_dma_packer adp_checker #(.ADDR_W(ADDR_W)) u_adp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .buf_arm   (buf_arm),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_ack   (req_ack),
    .buf_full  (buf_full),
    .overrun   (overrun),
    .cur_buf   (cur_buf)
);

// File: tb/audio_dma_packer_tb.sv
// Scoreboard bench: send_pair predicts words into a queue, a monitor
// process compares each request against the queue and acknowledges it.
module audio_dma_packer_tb;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int SMP_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_fmt;
    logic              cfg_big_endian;
    logic              smp_valid;
    logic [SMP_W-1:0]  smp_left, smp_right;
    logic [ADDR_W-1:0] buf0_base, buf1_base;
    logic [LEN_W-1:0]  buf0_len, buf1_len;
    logic [1:0]        buf_arm;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [31:0]       req_data;
    logic              req_ack;
    logic [1:0]        buf_full;
    logic              overrun;
    logic              cur_buf;

    always #2 clk = ~clk;

    audio_dma_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SMP_W(SMP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_big_endian(cfg_big_endian),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .buf0_base(buf0_base), .buf0_len(buf0_len), .buf1_base(buf1_base), .buf1_len(buf1_len),
        .buf_arm(buf_arm), .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ack(req_ack), .buf_full(buf_full), .overrun(overrun), .cur_buf(cur_buf)
    );

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    logic [63:0] exp_q[$];

    // Reference model state built from the requirements
    logic [1:0] m_ready = 2'b00;
    logic [1:0] m_full  = 2'b00;
    int         m_act   = 0;
    int         m_off   = 0;
    int         m_pos   = 0;
    logic [7:0] m_b[4];
    logic       exp_ovr = 1'b0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] to_u8(input logic [15:0] s);
        return {~s[15], s[14:8]};
    endfunction

    // Predict the effect of one pair, then drive it for one cycle
    task automatic send_pair(input logic [15:0] l, input logic [15:0] r, input bit force_drop);
        logic [7:0]  nb[4];
        int          n;
        logic [31:0] base, len, data;
        nb = '{default: 8'h00};
        case (cfg_fmt)
            2'd0: begin nb[0] = to_u8(l); n = 1; end
            2'd1: begin nb[0] = to_u8(l); nb[1] = to_u8(r); n = 2; end
            2'd2: begin
                nb[0] = cfg_big_endian ? l[15:8] : l[7:0];
                nb[1] = cfg_big_endian ? l[7:0]  : l[15:8];
                n = 2;
            end
            default: begin
                nb[0] = cfg_big_endian ? l[15:8] : l[7:0];
                nb[1] = cfg_big_endian ? l[7:0]  : l[15:8];
                nb[2] = cfg_big_endian ? r[15:8] : r[7:0];
                nb[3] = cfg_big_endian ? r[7:0]  : r[15:8];
                n = 4;
            end
        endcase
        if (force_drop || !m_ready[m_act]) begin
            exp_ovr = 1'b1;
        end else begin
            for (int k = 0; k < n; k++) m_b[m_pos + k] = nb[k];
            m_pos += n;
            if (m_pos == 4) begin
                base = (m_act == 1) ? buf1_base : buf0_base;
                len  = (m_act == 1) ? 32'(buf1_len) : 32'(buf0_len);
                data = cfg_big_endian ? {m_b[0], m_b[1], m_b[2], m_b[3]}
                                      : {m_b[3], m_b[2], m_b[1], m_b[0]};
                exp_q.push_back({base + 32'(m_off), data});
                m_pos = 0;
                m_off += 4;
                if (m_off == int'(len)) begin
                    m_full[m_act]  = 1'b1;
                    m_ready[m_act] = 1'b0;
                    m_act = 1 - m_act;
                    m_off = 0;
                end
            end
        end
        @(negedge clk);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic arm(input int i);
        @(negedge clk);
        buf_arm[i] = 1'b1;
        @(negedge clk);
        buf_arm = 2'b00;
        m_ready[i] = 1'b1;
        m_full[i]  = 1'b0;
        exp_ovr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_flags(input string tag);
        check({tag, " buf_full"}, {30'd0, buf_full}, {30'd0, m_full});
        check({tag, " overrun"},  {31'd0, overrun},  {31'd0, exp_ovr});
        check({tag, " cur_buf"},  {31'd0, cur_buf},  32'(m_act));
    endtask

    // Monitor: compare each request with the scoreboard, then acknowledge it
    initial begin
        logic [63:0] exp;
        logic [31:0] held;
        req_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected request", 32'd1, 32'd0);
                end else begin
                    exp = exp_q.pop_front();
                    check("R5 req_addr", req_addr, exp[63:32]);
                    check("R1 R2 R3 req_data", req_data, exp[31:0]);
                end
                held = req_data;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check("R4 held valid", {31'd0, req_valid}, 32'd1);
                    check("R4 held data", req_data, held);
                end
                req_ack = 1'b1;
                @(negedge clk);
                req_ack = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_fmt = 2'd3;
        cfg_big_endian = 1'b0;
        smp_valid = 1'b0;
        smp_left = '0;
        smp_right = '0;
        buf_arm = 2'b00;
        buf0_base = 32'h0000_1000;
        buf0_len  = 16'd8;
        buf1_base = 32'h0000_2000;
        buf1_len  = 16'd12;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: state after reset
        check("R9 req_valid", {31'd0, req_valid}, 32'd0);
        check_flags("R9 reset");

        // R8: nothing armed, the sample is dropped
        send_pair(16'h1234, 16'hABCD, 1'b0);
        check_flags("R8 unarmed drop");

        // R7: arming both clears overrun
        arm(0);
        arm(1);
        check_flags("R7 arm");

        // R1 R3: 16-bit stereo little-endian, fills buffer 0 (R6)
        cfg_fmt = 2'd3; cfg_big_endian = 1'b0;
        send_pair(16'h1234, 16'hABCD, 1'b0);
        send_pair(16'h8001, 16'h7FFE, 1'b0);
        check_flags("R6 switch to buffer 1");

        // R3: 16-bit mono big-endian
        cfg_fmt = 2'd2; cfg_big_endian = 1'b1;
        send_pair(16'hBEEF, 16'h5555, 1'b0);
        send_pair(16'h0102, 16'h5555, 1'b0);

        // R1: 8-bit mono big-endian, sign bit inverted
        cfg_fmt = 2'd0; cfg_big_endian = 1'b1;
        send_pair(16'h8000, 16'h0000, 1'b0);
        send_pair(16'h7F00, 16'h0000, 1'b0);
        send_pair(16'h0000, 16'h0000, 1'b0);
        send_pair(16'hFF00, 16'h0000, 1'b0);

        // R2: 8-bit stereo little-endian, left first; fills buffer 1
        cfg_fmt = 2'd1; cfg_big_endian = 1'b0;
        send_pair(16'h1200, 16'h3400, 1'b0);
        send_pair(16'h5600, 16'h7800, 1'b0);
        check_flags("R6 both full");

        // R8: no armed buffer
        send_pair(16'h1111, 16'h2222, 1'b0);
        check_flags("R8 no buffer");

        // R7: re-arm buffer 0, writing resumes at its base
        arm(0);
        check_flags("R7 rearm");
        send_pair(16'h9A00, 16'hBC00, 1'b0);
        send_pair(16'hDE00, 16'hF000, 1'b0);

        // R4 R8: stalled acknowledge makes a completing sample drop
        cfg_fmt = 2'd3; cfg_big_endian = 1'b0;
        stall = 5;
        send_pair(16'h0102, 16'h0304, 1'b0);
        send_pair(16'h0506, 16'h0708, 1'b1);
        check("R8 pending drop overrun", {31'd0, overrun}, 32'd1);
        repeat (10) @(negedge clk);
        stall = 0;
        check_flags("R6 after drain");

        arm(1);
        check_flags("R7 arm buffer 1");
        send_pair(16'h0A0B, 16'h0C0D, 1'b0);
        check_flags("R5 resume in buffer 1");

        repeat (4) @(negedge clk);
        check("R4 all words issued", 32'(exp_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule